// File: doc/BRIEF.md
# Low-Frequency Wake-Up Receiver Configuration Serializer

This block is a serial master that sets up and queries a low-frequency wake-up receiver. It uses three wires: a serial clock that rests low, an active-low chip select, and one data line that can be driven or released through an output enable. A host gives it one transaction at a time through a valid/ready request port. Each request carries a transaction kind and two byte fields. The block then runs the whole frame on its own.

There are three frame kinds, and each one is 16 clock pulses long. A command frame sends two raw bytes. A register write frame sends a fixed three-bit write code, a four-bit register address, a data byte and an odd parity bit. A read frame releases the data line, gives seven pulses that are not captured, captures eight bits most significant first, and then gives one more pulse for the parity bit. The end of every frame is marked by a one-cycle response pulse, and a read also returns the captured byte with it. One parameter sets how long each clock phase lasts.

The request port is the only back-pressured interface. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response has no ready input: `rsp_valid` is high for exactly one cycle, and `rsp_data` keeps its value until the next request is accepted. The host can therefore read it at any later time.

Top module: `lfrx_cfg_serializer`

## Requirements
- R1: After reset, and whenever no transaction is running, `cs_n` is 1, `sclk` is 0, `sdo_oe` is 0, `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: Once a request is accepted, `cs_n` stays high for exactly PHASE_CYC further cycles. It then goes low and stays low without a break until the frame ends.
- R3: Every bit has a low phase of PHASE_CYC cycles with `sclk`=0, then a high phase of PHASE_CYC cycles with `sclk`=1. `sdo` does not change across a low phase and the high phase that follows it. Each frame has exactly 16 pulses.
- R4: A command frame (`req_kind`=2'b00) sends `req_data` and then `req_aux`, each MSB first. `sdo_oe` is 1 on all 16 pulses.
- R5: A write frame (`req_kind`=2'b01) sends, MSB first, the bits 1,1,1, then `req_aux[3:0]`, then `req_data`, then a parity bit. `sdo_oe` is 1 on all 16 pulses.
- R6: The parity bit of a write frame is set so that `req_data` and the parity bit together hold an odd number of ones.
- R7: In a read frame (`req_kind`=2'b10), `sdo_oe` is 0 for the whole frame. `sdi` is sampled on the last cycle of each high phase. Pulses 1 to 7 and pulse 16 are not captured. Pulses 8 to 15 are shifted into the result MSB first.
- R8: After the last high phase, `cs_n` goes high and `sdo_oe` is 0. In that same cycle `rsp_valid` is 1 for exactly one cycle. `rsp_data` holds the byte captured by the last read until the next request is accepted.
- R9: While a transaction runs, `req_ready` is 0 and `req_valid` is ignored. The frame on the wire does not change, and no second frame starts afterwards.
- R10: `req_kind`=2'b11 runs a command frame, identical to `req_kind`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 00/11 command, 01 register write, 10 register read |
| req_data | input | 8 | First command byte, or write data |
| req_aux | input | 8 | Second command byte, or register address in bits 3:0 |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle end-of-frame pulse |
| rsp_data | output | 8 | Byte captured by the last read |
| sclk | output | 1 | Serial clock, rests low |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | 1 | Data line output value |
| sdo_oe | output | 1 | Data line output enable |
| sdi | input | 1 | Data line input value |

## Verification
The case that is hardest to reach from the ports is a read capture that has to skip exactly seven leading pulses and ignore the trailing parity pulse. A capture window shifted by one pulse would still return a believable byte. To expose it, the bench acts as the receiver. It counts the rising edges of `sclk` and sets `sdi` on each one. During the pulses that must not be captured it drives a pattern that is clearly different from the data byte, so any shift of the window changes `rsp_data`. The bench also raises `req_valid` in the middle of a frame with conflicting fields, and then confirms that neither the frame on the wire nor the time after it is affected.

// File: rtl/lfrx_cfg_pkg.sv
package lfrx_cfg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int SKIP_PULSES = 7;
  localparam int CAP_BITS   = 8;
  localparam int PIDX_W     = $clog2(FRAME_BITS);
  localparam logic [2:0] WR_CODE = 3'b111;

  typedef enum logic [1:0] {
    KIND_CMD     = 2'b00,
    KIND_WR      = 2'b01,
    KIND_RD      = 2'b10,
    KIND_CMD_ALT = 2'b11
  } lfrx_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } lfrx_state_e;
endpackage

// File: rtl/lfrx_phase_timer.sv
module lfrx_phase_timer #(
  parameter int PHASE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R3
  phase_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R1
  phase_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/lfrx_frame_build.sv
module lfrx_frame_build
  import lfrx_cfg_pkg::*;
(
  input  logic [1:0]            kind,
  input  logic [DATA_W-1:0]     data,
  input  logic [DATA_W-1:0]     aux,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  drive
);
  logic odd_par;
  assign odd_par = ~(^data);

  always_comb begin
    unique case (lfrx_kind_e'(kind))
      KIND_WR: frame = {WR_CODE, aux[ADDR_W-1:0], data, odd_par};
      KIND_RD: frame = '0;
      default: frame = {data, aux};
    endcase
    drive = (lfrx_kind_e'(kind) != KIND_RD);
  end
endmodule

// File: rtl/lfrx_rd_capture.sv
module lfrx_rd_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] byte_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        byte_q <= '0;
    else if (clear)    byte_q <= '0;
    else if (shift_en) byte_q <= {byte_q[W-2:0], sdi};
  end

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !shift_en |=> $stable(byte_q));
endmodule

// File: rtl/lfrx_cfg_serializer.sv
module lfrx_cfg_serializer
  import lfrx_cfg_pkg::*;
#(
  parameter int PHASE_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [DATA_W-1:0]   req_aux,
  output logic                busy,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                sclk,
  output logic                cs_n,
  output logic                sdo,
  output logic                sdo_oe,
  input  logic                sdi
);
  localparam logic [PIDX_W-1:0] LAST_PULSE = PIDX_W'(FRAME_BITS - 1);
  localparam logic [PIDX_W-1:0] CAP_FIRST  = PIDX_W'(SKIP_PULSES);
  localparam logic [PIDX_W-1:0] CAP_LAST   = PIDX_W'(SKIP_PULSES + CAP_BITS - 1);

  lfrx_state_e             state_q;
  logic [FRAME_BITS-1:0]   shreg_q;
  logic [PIDX_W-1:0]       pulse_q;
  logic                    drive_q;
  logic [FRAME_BITS-1:0]   frame_w;
  logic                    drive_w;
  logic                    expire;
  logic                    accept;
  logic                    run;
  logic                    in_frame;
  logic                    cap_en;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign run      = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign in_frame = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign cap_en   = (state_q == ST_HIGH) && expire && !drive_q &&
                    (pulse_q >= CAP_FIRST) && (pulse_q <= CAP_LAST);

  lfrx_frame_build u_build (
    .kind  (req_kind),
    .data  (req_data),
    .aux   (req_aux),
    .frame (frame_w),
    .drive (drive_w)
  );

  lfrx_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .expire (expire)
  );

  lfrx_rd_capture #(.W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .shift_en (cap_en),
    .sdi      (sdi),
    .byte_q   (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      pulse_q <= '0;
      drive_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          shreg_q <= frame_w;
          drive_q <= drive_w;
          pulse_q <= '0;
          state_q <= ST_LEAD;
        end
        ST_LEAD: if (expire) state_q <= ST_LOW;
        ST_LOW:  if (expire) state_q <= ST_HIGH;
        ST_HIGH: if (expire) begin
          shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
          if (pulse_q == LAST_PULSE) begin
            state_q <= ST_DONE;
          end else begin
            pulse_q <= pulse_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign cs_n      = !in_frame;
  assign sclk      = (state_q == ST_HIGH);
  assign sdo_oe    = in_frame && drive_q;
  assign sdo       = sdo_oe && shreg_q[FRAME_BITS-1];

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R3
  sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));
  // R2
  accept_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cs_n && busy && !req_ready);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  // R8
  rsp_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cs_n && !sdo_oe && $past(sclk));
  // R6
  wr_parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'b01 |=> ^shreg_q[DATA_W:0]);
  // R7
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'b10 |=> !drive_q);
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_valid |=> $stable(drive_q));
endmodule

// File: tb/lfrx_cfg_serializer_tb_top.sv
module lfrx_cfg_serializer_tb_top;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_data = 8'h00;
  logic [7:0] req_aux = 8'h00;
  logic       sdi = 1'b0;
  logic       req_ready, busy, rsp_valid, sclk, cs_n, sdo, sdo_oe;
  logic [7:0] rsp_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] got_bits;
  int          got_pulses, got_oe, got_lead;
  bit          bad_phase, cs_glitch, got_rsp, rsp_cs_ok, post_ok, poke_ready;
  logic [7:0]  got_rd;

  always #2.5 clk = ~clk;

  lfrx_cfg_serializer #(.PHASE_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .req_aux(req_aux), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sclk(sclk), .cs_n(cs_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic [7:0] d, input logic [7:0] a,
                         input logic [7:0] slave_byte, input bit poke);
    bit prev_sclk, seen_low;
    int hi_len, lo_len;
    @(negedge clk);
    req_kind = kind; req_data = d; req_aux = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_data = 8'h00; req_aux = 8'h00;
    got_bits = '0; got_pulses = 0; got_oe = 0; got_lead = 0;
    bad_phase = 0; cs_glitch = 0; got_rsp = 0; rsp_cs_ok = 0; post_ok = 0;
    poke_ready = 0; prev_sclk = 0; seen_low = 0; hi_len = 0; lo_len = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (poke && cyc == 10) begin
        req_kind = 2'b01; req_data = 8'hFF; req_aux = 8'h0F; req_valid = 1'b1;
        poke_ready = req_ready;
      end
      if (poke && cyc == 11) req_valid = 1'b0;
      if (sclk) hi_len++;
      else if (prev_sclk) begin
        if (hi_len != HALF) bad_phase = 1;
        hi_len = 0;
      end
      if (!cs_n && !sclk) lo_len++;
      if (sclk && !prev_sclk) begin
        if (lo_len != HALF) bad_phase = 1;
        lo_len = 0;
        if (got_pulses < 16) got_bits[15 - got_pulses] = sdo;
        got_oe += int'(sdo_oe);
        if (got_pulses >= 7 && got_pulses <= 14) sdi = slave_byte[14 - got_pulses];
        else sdi = ~slave_byte[7 - (got_pulses % 8)];
        got_pulses++;
      end
      if (rsp_valid) begin
        got_rsp = 1; rsp_cs_ok = cs_n && !sdo_oe; got_rd = rsp_data;
        break;
      end
      if (cs_n && !seen_low) got_lead++;
      if (!cs_n) seen_low = 1;
      if (cs_n && seen_low) cs_glitch = 1;
      prev_sclk = sclk;
      @(negedge clk);
    end
    @(negedge clk);
    post_ok = !rsp_valid && req_ready && cs_n && !busy && (rsp_data == got_rd);
  endtask

  task automatic check_common(input string tag, input int exp_oe);
    check({tag, " R3 pulse count"}, got_pulses, 16);
    check({tag, " R3 phase lengths"}, bad_phase, 0);
    check({tag, " R2 lead cycles"}, got_lead, HALF);
    check({tag, " R2 cs held low"}, cs_glitch, 0);
    check({tag, " R8 rsp with cs high"}, {got_rsp, rsp_cs_ok}, 2'b11);
    check({tag, " R8 one-cycle rsp"}, post_ok, 1);
    check({tag, " output enable pulses"}, got_oe, exp_oe);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle pins", {cs_n, sclk, sdo_oe, req_ready, busy, rsp_valid}, 6'b100100);
  endtask

  task automatic t_cmd;
    run_txn(2'b00, 8'hA0, 8'h00, 8'h00, 0);
    check("R4 cmd bits A0/00", got_bits, 16'hA000);
    check_common("R4 cmd", 16);
    run_txn(2'b00, 8'h20, 8'h5C, 8'h00, 0);
    check("R4 cmd bits 20/5C", got_bits, 16'h205C);
  endtask

  task automatic t_write;
    // R5 R6: 0xA4 has 3 ones -> parity 0
    run_txn(2'b01, 8'hA4, 8'h00, 8'h00, 0);
    check("R5 write addr0 A4", got_bits, {3'b111, 4'h0, 8'hA4, 1'b0});
    check_common("R5 write", 16);
    // R6: 0x9F has 6 ones -> parity 1
    run_txn(2'b01, 8'h9F, 8'hF5, 8'h00, 0);
    check("R6 write addr5 9F parity", got_bits, {3'b111, 4'h5, 8'h9F, 1'b1});
    run_txn(2'b01, 8'h00, 8'h06, 8'h00, 0);
    check("R6 write zero data parity", got_bits, {3'b111, 4'h6, 8'h00, 1'b1});
  endtask

  task automatic t_read;
    run_txn(2'b10, 8'h77, 8'h33, 8'hC5, 0);
    check("R7 read byte C5", got_rd, 8'hC5);
    check("R7 data line undriven", got_bits, 16'h0000);
    check_common("R7 read", 0);
    run_txn(2'b10, 8'h00, 8'h00, 8'h3A, 0);
    check("R7 read byte 3A", got_rd, 8'h3A);
    repeat (4) @(negedge clk);
    check("R8 rsp_data held", rsp_data, 8'h3A);
    run_txn(2'b00, 8'h11, 8'h22, 8'h00, 0);
    check("R8 rsp_data cleared by new request", rsp_data, 8'h00);
  endtask

  task automatic t_busy;
    run_txn(2'b00, 8'hC3, 8'h81, 8'h00, 1);
    check("R9 ready low while busy", poke_ready, 0);
    check("R9 frame unchanged", got_bits, 16'hC381);
    repeat (6) begin
      @(negedge clk);
      check("R9 no second frame", {cs_n, busy}, 2'b10);
    end
  endtask

  task automatic t_kind3;
    run_txn(2'b11, 8'h6B, 8'hD2, 8'h00, 0);
    check("R10 kind 11 as command", got_bits, 16'h6BD2);
    check("R10 kind 11 oe", got_oe, 16);
  endtask

  initial begin
    t_reset;
    t_cmd;
    t_write;
    t_read;
    t_busy;
    t_kind3;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule